// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a simple register bus and fronts a one-time-programmable fuse array of 16 banks of 8 words, 32 bits each. The array is held in an internal register array. Software selects a fuse word by its linear index, bank times 8 plus word. It then starts one of two operations. A sense copies the fuse word into a read-data register. A program ORs a data word into the fuse word, and software must first place a 16-bit unlock key in the control register. The unlock field drops back to zero when the program finishes, so every program needs the key again.

Both operations run for a software-chosen number of clock cycles taken from a timing register, and a busy flag covers the whole run. A program first waits one relax period, then holds the fuse strobe output high, then waits a second relax period. Both relax periods come out of the programmed count. Illegal requests set a sticky error flag, which only a write to a separate clear alias resets. The block also holds one shadow register per fuse word. Software can read and overwrite each shadow at any time, and doing so never touches the fuse array.

Top module: `otp_fuse_ctl`

## Requirements
- R1: After reset, every readable location returns 0 and prog_strobe_o is low. This includes the control, timing, program-data and sensed-data registers and all shadows.
- R2: Control register, offset 0. Bits 31:16 hold the unlock field, bit 9 the error flag, bit 8 busy, and bits 6:0 the fuse index (bank*8+word). The other bits read 0. A write updates only the unlock field and the index; bits 9 and 8 cannot be written.
- R3: Writing a value with bit 0 set to offset 3 starts a sense when the block is idle. Busy reads 1 for exactly S+1 cycles, starting in the cycle after the write, where S is the sense count. When busy falls, offset 5 holds the addressed fuse word.
- R4: With the unlock field equal to 0x3E77 and the block idle, a write to offset 4 starts a program lasting P+1 busy cycles, where P is the program count. Offset 4 then reads back the accepted data. At the end the fuse word becomes its old value OR the data, so bits only go from 0 to 1.
- R5: Number the busy cycles of a program from 0, and let L = relax+1. prog_strobe_o is high in cycles L through P-L inclusive and low at all other times, including the whole of a sense.
- R6: A write to offset 4 without the correct key sets the error flag. It starts nothing, and it changes neither the fuse word nor the program-data register.
- R7: A sense or program request made while busy sets the error flag and leaves the running operation untouched. While busy, writes to the control and timing registers are ignored.
- R8: The error flag stays set until a write with bit 9 set reaches the clear alias at offset 1. Writing bit 9 through offset 0 does not clear it.
- R9: The unlock field reads 0 from the cycle after a program finishes.
- R10: Offsets 0x80 to 0xFF are the shadow registers for fuse indices 0 to 127. They can be read and written at any time, and they are independent of fuse contents and of operations.
- R11: Timing register, offset 2. Bits 21:16 hold the sense count, bits 15:12 the relax count and bits 11:0 the program count. It reads back as written, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one write per asserted cycle |
| reg_addr | input | 8 | Register offset; bit 7 selects the shadow region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| prog_strobe_o | output | 1 | High during the active fuse program window |

## Verification
The case that matters most is a new request arriving in the last busy cycle of an operation. In that same clock edge the operation completes: it latches the sensed word or updates the fuse, and it clears the unlock field. The bench provokes this by waiting, with the help of its own reference model, for the final busy cycle and then writing a sense request. The request must be judged against the busy value seen before the edge. So the error flag must set, no new operation may start, and the completion must still deliver its result. The control register, sensed data and strobe are compared against the model on every cycle around that edge.

// File: rtl/otp_fuse_ctl.sv
module otp_fuse_ctl #(
  parameter int BANKS = 16,
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int KW    = 16,
  parameter logic [15:0] KEY = 16'h3E77,
  parameter int OFFW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [OFFW-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            prog_strobe_o
);
  localparam int NW = BANKS * WORDS;
  localparam int AW = $clog2(NW);
  localparam int CW = 13;
  localparam logic [2:0] OFF_CTRL = 3'd0, OFF_CLR = 3'd1, OFF_TIME = 3'd2,
                         OFF_RCMD = 3'd3, OFF_DATA = 3'd4, OFF_RDAT = 3'd5;

  logic [KW-1:0] unlock_q;
  logic [AW-1:0] addr_q;
  logic          err_q, busy_q, prog_q;
  logic [5:0]    trd_q;
  logic [3:0]    trl_q;
  logic [11:0]   tpg_q;
  logic [CW-1:0] el_q, lim_q;
  logic [DW-1:0] rdata_q, wdata_q;
  logic [DW-1:0] fuse_q [NW];
  logic [DW-1:0] shad_q [NW];

  logic          is_shad, is_reg, wr_reg;
  logic [2:0]    off;
  logic [AW-1:0] sidx;
  logic          sense_req, prog_req, key_ok, start_sense, start_prog, set_err, clr_err, done;
  logic [CW-1:0] rl1;

  assign is_shad     = reg_addr[OFFW-1];
  assign sidx        = reg_addr[AW-1:0];
  assign off         = reg_addr[2:0];
  assign is_reg      = !is_shad && (reg_addr[OFFW-2:3] == '0);
  assign wr_reg      = reg_we && is_reg;
  assign sense_req   = wr_reg && off == OFF_RCMD && reg_wdata[0];
  assign prog_req    = wr_reg && off == OFF_DATA;
  assign clr_err     = wr_reg && off == OFF_CLR && reg_wdata[9];
  assign key_ok      = unlock_q == KEY;
  assign start_sense = sense_req && !busy_q;
  assign start_prog  = prog_req && !busy_q && key_ok;
  assign set_err     = ((sense_req || prog_req) && busy_q) || (prog_req && !busy_q && !key_ok);
  assign done        = busy_q && el_q == lim_q;
  assign rl1         = CW'(trl_q) + 1'b1;

  assign prog_strobe_o = busy_q && prog_q && el_q >= rl1 && (lim_q - el_q) >= rl1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= '0;
      addr_q   <= '0;
      err_q    <= 1'b0;
      busy_q   <= 1'b0;
      prog_q   <= 1'b0;
      trd_q    <= '0;
      trl_q    <= '0;
      tpg_q    <= '0;
      el_q     <= '0;
      lim_q    <= '0;
      rdata_q  <= '0;
      wdata_q  <= '0;
    end else begin
      if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          if (prog_q) unlock_q <= '0;
          else        rdata_q  <= fuse_q[addr_q];
        end else begin
          el_q <= el_q + 1'b1;
        end
      end
      if (wr_reg && !busy_q && off == OFF_CTRL) begin
        unlock_q <= reg_wdata[31:16];
        addr_q   <= reg_wdata[AW-1:0];
      end
      if (wr_reg && !busy_q && off == OFF_TIME) begin
        trd_q <= reg_wdata[21:16];
        trl_q <= reg_wdata[15:12];
        tpg_q <= reg_wdata[11:0];
      end
      if (start_sense) begin
        busy_q <= 1'b1;
        prog_q <= 1'b0;
        el_q   <= '0;
        lim_q  <= CW'(trd_q);
      end
      if (start_prog) begin
        busy_q  <= 1'b1;
        prog_q  <= 1'b1;
        el_q    <= '0;
        lim_q   <= CW'(tpg_q);
        wdata_q <= reg_wdata;
      end
      if (set_err)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) fuse_q[i] <= '0;
    end else if (done && prog_q) begin
      fuse_q[addr_q] <= fuse_q[addr_q] | wdata_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) shad_q[i] <= '0;
    end else if (reg_we && is_shad) begin
      shad_q[sidx] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (is_shad) reg_rdata = shad_q[sidx];
    else if (is_reg) begin
      case (off)
        OFF_CTRL: reg_rdata = {unlock_q, 6'b0, err_q, busy_q, {(8-AW){1'b0}}, addr_q};
        OFF_TIME: reg_rdata = {10'b0, trd_q, trl_q, tpg_q};
        OFF_DATA: reg_rdata = wdata_q;
        OFF_RDAT: reg_rdata = rdata_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);
  a_r4_bits_only_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_q) |=> ((fuse_q[$past(addr_q)] & $past(fuse_q[addr_q])) == $past(fuse_q[addr_q])));
  a_r6_nokey_err: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !busy_q && !key_ok) |=> (err_q && !busy_q));
  a_r7_busy_req_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (sense_req || prog_req)) |=> (err_q && busy_q == $past(!done)));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> err_q);
  a_r9_unlock_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(busy_q) && prog_q) |-> (unlock_q == '0));
endmodule

// File: tb/otp_fuse_ctl_tb.sv
module otp_fuse_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEYW = 32'h3E77_0000;

  logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        prog_strobe_o;

  otp_fuse_ctl u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prog_strobe_o(prog_strobe_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit m_busy, m_prog, m_err;
  int m_el, m_lim, m_rd, m_rl, m_pg, m_addr;
  logic [15:0] m_unlock;
  logic [31:0] m_rdata, m_wdata;
  logic [31:0] m_fuse [128];
  logic [31:0] m_shad [128];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[7]) return m_shad[a[6:0]];
    if (a[6:3] != 0) return 0;
    case (a[2:0])
      3'd0: return {m_unlock, 6'b0, m_err, m_busy, 1'b0, 7'(m_addr)};
      3'd2: return {10'b0, 6'(m_rd), 4'(m_rl), 12'(m_pg)};
      3'd4: return m_wdata;
      3'd5: return m_rdata;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_strobe();
    return m_busy && m_prog && m_el >= m_rl + 1 && (m_lim - m_el) >= m_rl + 1;
  endfunction

  task automatic m_step(input bit we, input logic [7:0] a, input logic [31:0] d);
    bit ob = m_busy;
    bit isr = we && !a[7] && a[6:3] == 0;
    if (m_busy) begin
      if (m_el == m_lim) begin
        m_busy = 0;
        if (m_prog) begin m_fuse[m_addr] = m_fuse[m_addr] | m_wdata; m_unlock = 0; end
        else m_rdata = m_fuse[m_addr];
      end else m_el++;
    end
    if (we && a[7]) m_shad[a[6:0]] = d;
    if (isr) begin
      case (a[2:0])
        3'd0: if (!ob) begin m_unlock = d[31:16]; m_addr = d[6:0]; end
        3'd1: if (d[9]) m_err = 0;
        3'd2: if (!ob) begin m_rd = d[21:16]; m_rl = d[15:12]; m_pg = d[11:0]; end
        3'd3: if (d[0]) begin
                if (ob) m_err = 1;
                else begin m_busy = 1; m_prog = 0; m_el = 0; m_lim = m_rd; end
              end
        3'd4: if (ob || m_unlock != 16'h3E77) m_err = 1;
              else begin m_busy = 1; m_prog = 1; m_el = 0; m_lim = m_pg; m_wdata = d; end
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    #1;
    if (!we) check(tag, reg_rdata, m_read(a));
    check("R5", 32'(prog_strobe_o), 32'(m_strobe()));
    @(posedge clk);
    m_step(we, a, d);
  endtask

  task automatic poll(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_busy = 0; m_prog = 0; m_err = 0; m_el = 0; m_lim = 0;
    m_rd = 0; m_rl = 0; m_pg = 0; m_addr = 0; m_unlock = 0; m_rdata = 0; m_wdata = 0;
    for (int i = 0; i < 128; i++) begin m_fuse[i] = 0; m_shad[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cyc(0, 8'h00, 0, "R1"); cyc(0, 8'h02, 0, "R1"); cyc(0, 8'h04, 0, "R1");
    cyc(0, 8'h05, 0, "R1"); cyc(0, 8'h93, 0, "R1");
    check("R1", 32'(prog_strobe_o), 0);

    cyc(1, 8'h02, {10'b0, 6'd5, 4'd1, 12'd9}, "R11"); cyc(0, 8'h02, 0, "R11");
    cyc(1, 8'h00, 32'h0000_0313, "R2"); cyc(0, 8'h00, 0, "R2");

    cyc(1, 8'h03, 1, "R3"); poll(8, "R3"); cyc(0, 8'h05, 0, "R3");

    cyc(1, 8'h04, 32'h1234, "R6"); cyc(0, 8'h00, 0, "R6"); cyc(0, 8'h04, 0, "R6");
    cyc(1, 8'h00, 32'h0000_0213, "R8"); cyc(0, 8'h00, 0, "R8");
    cyc(1, 8'h01, 32'h0000_0200, "R8"); cyc(0, 8'h00, 0, "R8");

    cyc(1, 8'h00, KEYW | 32'h13, "R9"); cyc(0, 8'h00, 0, "R9");
    cyc(1, 8'h04, 32'h0000_F00F, "R4"); poll(12, "R9"); cyc(0, 8'h04, 0, "R4");

    cyc(1, 8'h00, KEYW | 32'h13, "R4");
    cyc(1, 8'h04, 32'h00FF_0000, "R4");
    cyc(1, 8'h03, 1, "R7");
    cyc(1, 8'h00, 32'h0000_0005, "R7");
    cyc(1, 8'h02, 32'h0, "R7");
    cyc(0, 8'h00, 0, "R7");
    cyc(1, 8'h01, 32'h200, "R8");
    while (!(m_busy && m_el == m_lim)) cyc(0, 8'h00, 0, "R7");
    cyc(1, 8'h03, 1, "R7");
    poll(3, "R7"); cyc(0, 8'h05, 0, "R7"); cyc(0, 8'h02, 0, "R11");
    cyc(1, 8'h01, 32'h200, "R8");
    cyc(1, 8'h03, 1, "R4"); poll(8, "R4"); cyc(0, 8'h05, 0, "R4");

    cyc(1, 8'h85, 32'hA5A5_5A5A, "R10"); cyc(1, 8'hFF, 32'hDEAD_BEEF, "R10");
    cyc(0, 8'h85, 0, "R10"); cyc(0, 8'hFF, 0, "R10"); cyc(0, 8'h93, 0, "R10");
    cyc(1, 8'h00, KEYW | 32'h05, "R10"); cyc(1, 8'h04, 32'h0000_0100, "R10");
    cyc(1, 8'h85, 32'h1111_2222, "R10"); poll(10, "R10"); cyc(0, 8'h85, 0, "R10");
    cyc(1, 8'h03, 1, "R3"); poll(7, "R3"); cyc(0, 8'h05, 0, "R3");

    cyc(1, 8'h02, {10'b0, 6'd0, 4'd0, 12'd1}, "R11");
    cyc(1, 8'h00, KEYW | 32'h7F, "R5"); cyc(1, 8'h04, 32'h8000_0001, "R5"); poll(4, "R5");
    cyc(1, 8'h03, 1, "R3"); poll(2, "R3"); cyc(0, 8'h05, 0, "R3");
    cyc(1, 8'h02, {10'b0, 6'd63, 4'd3, 12'd20}, "R11");
    cyc(1, 8'h00, KEYW | 32'h40, "R5"); cyc(1, 8'h04, 32'h0F0F_0F0F, "R5"); poll(24, "R5");
    cyc(1, 8'h03, 1, "R3"); poll(66, "R3"); cyc(0, 8'h05, 0, "R3");
    cyc(1, 8'h02, {10'b0, 6'd3, 4'd2, 12'd11}, "R11");

    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 7);
      logic [31:0] r = $urandom;
      case (op)
        0: cyc(1, 8'h00, (r[0] ? KEYW : 32'h0) | 32'(r[6:4]), "R2");
        1: cyc(1, 8'h03, 1, "R3");
        2: cyc(1, 8'h04, r, "R4");
        3: cyc(1, 8'h01, 32'h200, "R8");
        4: cyc(1, {1'b1, r[14:8]}, r, "R10");
        5: cyc(0, 8'h05, 0, "R3");
        6: cyc(0, {1'b1, r[14:8]}, 0, "R10");
        default: cyc(0, 8'h00, 0, "R7");
      endcase
    end
    poll(20, "R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule